// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block sits behind the serial front end of a small non-volatile memory. It holds the device status byte and decides whether each write request is allowed. The front end hands it single-cycle decoded commands: set the write-enable latch, clear the latch, write the status byte, and write the array at an address. The block answers each write with a one-cycle grant or deny pulse. A granted write starts a self-timed busy period whose length is a cycle count. During that period the block rejects further writes.

Two mechanisms limit writes. A two-bit block-protect field reserves the upper quarter, the upper half or all of the address space. A hardware protect pin guards the status byte, but only while a protect-enable bit in that same byte is set. A status write is held pending until chip select rises. It is committed at that point, and the busy cycle begins. If the pin drops while the write is still pending, the write is cancelled. Once the busy cycle has begun, the pin has no effect on it.

Top module: `sr_guard`

## Requirements
- R1: After reset, `status` is 8'h00 and all four grant and deny outputs are low. The status layout is: bit 0 busy, bit 1 write-enable latch, bits 3:2 block-protect, bit 7 protect-enable, bits 6:4 always zero.
- R2: `cmd_wren` sets the latch and `cmd_wrdi` clears it. Both are ignored while busy.
- R3: An array write or a status write requested while the latch is clear is denied.
- R4: An array write is denied when its address is protected. Block-protect 00 protects nothing. 01 protects addresses whose top two bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address. An unprotected write with the latch set is granted.
- R5: When the protect-enable bit is 1 and `wp_n` is low, a status write request is denied and the status byte is unchanged. With `wp_n` high, the same write is granted.
- R6: When the protect-enable bit is 0, the level of `wp_n` has no effect on status writes.
- R7: If `wp_n` goes low while an accepted status write is pending and the protect-enable bit is 1, the write is cancelled. `sr_deny` pulses one cycle later and the status byte is unchanged.
- R8: A status write is committed on the first cycle in which `cs_n` is high while the write is pending. After that, a low `wp_n` does not shorten the busy cycle or undo the new value.
- R9: A granted write keeps the busy bit high for exactly WRITE_CYCLES cycles. Busy and the latch then clear together. Any write requested while busy is denied.
- R10: A denied write clears the latch.
- R11: A status write changes only block-protect (data bits 3:2) and protect-enable (data bit 7). The data bits in the busy, latch and reserved positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, low while a command frame is open |
| cmd_wren | input | 1 | Set write-enable latch (one-cycle pulse) |
| cmd_wrdi | input | 1 | Clear write-enable latch (one-cycle pulse) |
| cmd_wrsr | input | 1 | Status write request (one-cycle pulse) |
| cmd_write | input | 1 | Array write request (one-cycle pulse) |
| wr_addr | input | ADDR_W | Address of the array write |
| sr_data | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| arr_grant | output | 1 | Array write accepted (pulse) |
| arr_deny | output | 1 | Array write rejected (pulse) |
| sr_grant | output | 1 | Status write committed (pulse) |
| sr_deny | output | 1 | Status write rejected or cancelled (pulse) |
| status | output | 8 | Current status byte |

## Verification
The assertions assume that the front end raises at most one command pulse per cycle. They also assume that commands arrive only while `cs_n` is low. The exclusive grant and deny property depends on both. The bench drives each command as an isolated one-cycle pulse, changing inputs on the falling clock edge. It keeps `cs_n` low around every command and raises it only to commit a pending status write or to idle. Pin changes come on their own cycles, so the cancel case and the already-started case are each reached in a single, defined cycle.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W       = 13,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        sr_data,
  input  logic              wp_n,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic              sr_grant,
  output logic              sr_deny,
  output logic [7:0]        status
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic             busy, wel, wpen, pend, pend_wpen;
  logic [1:0]       bp, pend_bp;
  logic [CNT_W-1:0] cnt;
  logic             prot_hit;

  always_comb begin
    case (bp)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = &wr_addr[ADDR_W-1:ADDR_W-2];
      2'b10:   prot_hit = wr_addr[ADDR_W-1];
      default: prot_hit = 1'b1;
    endcase
  end

  wire hw_lock = wpen & ~wp_n;
  wire arr_ok  = wel & ~busy & ~pend & ~prot_hit;
  wire sr_ok   = wel & ~busy & ~pend & ~hw_lock;
  wire cancel  = pend & hw_lock;
  wire commit  = pend & ~hw_lock & cs_n;
  wire done    = busy && (cnt == '0);

  assign status = {wpen, 3'b000, bp, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wel <= 1'b0; wpen <= 1'b0; bp <= 2'b00;
      pend <= 1'b0; pend_bp <= 2'b00; pend_wpen <= 1'b0; cnt <= '0;
      arr_grant <= 1'b0; arr_deny <= 1'b0; sr_grant <= 1'b0; sr_deny <= 1'b0;
    end else begin
      arr_grant <= 1'b0; arr_deny <= 1'b0; sr_grant <= 1'b0; sr_deny <= 1'b0;
      if (done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (cmd_wren && !busy) wel <= 1'b1;
      if (cmd_wrdi && !busy) wel <= 1'b0;
      if (cmd_write) begin
        if (arr_ok) begin
          arr_grant <= 1'b1;
          busy      <= 1'b1;
          cnt       <= CNT_W'(WRITE_CYCLES - 1);
        end else begin
          arr_deny <= 1'b1;
          wel      <= 1'b0;
        end
      end
      if (cmd_wrsr) begin
        if (sr_ok) begin
          pend      <= 1'b1;
          pend_bp   <= sr_data[3:2];
          pend_wpen <= sr_data[7];
        end else begin
          sr_deny <= 1'b1;
          wel     <= 1'b0;
        end
      end
      if (cancel) begin
        pend    <= 1'b0;
        sr_deny <= 1'b1;
        wel     <= 1'b0;
      end else if (commit) begin
        pend     <= 1'b0;
        bp       <= pend_bp;
        wpen     <= pend_wpen;
        sr_grant <= 1'b1;
        busy     <= 1'b1;
        cnt      <= CNT_W'(WRITE_CYCLES - 1);
      end
    end
  end

  // R3: a grant is only ever seen with the latch set
  a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_grant || sr_grant) |-> status[1]);

  // R5: while the pin lock is active, the protect fields cannot change
  a_r5_locked_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |=> $stable(status[7:2]));

  // R9: busy only starts together with a grant
  a_r9_busy_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (arr_grant || sr_grant));

  // R9: no grant issued during an ongoing busy cycle
  a_r9_no_grant_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> !(arr_grant || sr_grant));

  // R1: at most one answer pulse per cycle
  a_r1_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_grant, arr_deny, sr_grant, sr_deny}));
endmodule

// File: tb/sr_guard_test.sv
module sr_guard_test;
  localparam int AW = 13;
  localparam int W  = 12;

  logic clk = 0, rst_n = 0, cs_n = 1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, wp_n = 1;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] sr_data = '0;
  logic arr_grant, arr_deny, sr_grant, sr_deny;
  logic [7:0] status;
  int tests = 0, fails = 0;

  sr_guard #(.ADDR_W(AW), .WRITE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write), .wr_addr(wr_addr), .sr_data(sr_data),
    .wp_n(wp_n), .arr_grant(arr_grant), .arr_deny(arr_deny), .sr_grant(sr_grant),
    .sr_deny(sr_deny), .status(status));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wren;
    cs_n = 0; cmd_wren = 1; @(negedge clk); cmd_wren = 0; cs_n = 1; @(negedge clk);
  endtask

  task automatic wrdi;
    cs_n = 0; cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0; cs_n = 1; @(negedge clk);
  endtask

  task automatic arr_write(logic [AW-1:0] a);
    cs_n = 0; wr_addr = a; cmd_write = 1; @(negedge clk); cmd_write = 0; cs_n = 1;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
  endtask

  task automatic sr_write(logic [7:0] d, bit expect_ok, string req);
    int n;
    cs_n = 0; sr_data = d; cmd_wrsr = 1; @(negedge clk); cmd_wrsr = 0;
    if (!expect_ok) begin
      chk(req, {sr_grant, sr_deny}, 2'b01);
      cs_n = 1; @(negedge clk);
      return;
    end
    cs_n = 1; @(negedge clk);
    chk(req, {sr_grant, sr_deny}, 2'b10);
    wait_busy(n);
  endtask

  task automatic t_reset;
    chk("R1", status, 8'h00);
    chk("R1", {arr_grant, arr_deny, sr_grant, sr_deny}, 0);
  endtask

  task automatic t_latch;
    wren; chk("R2", status[1], 1);
    wrdi; chk("R2", status[1], 0);
  endtask

  task automatic t_no_latch;
    arr_write(0); chk("R3", {arr_grant, arr_deny}, 2'b01); @(negedge clk);
    sr_write(8'h0C, 0, "R3"); chk("R3", status, 8'h00);
  endtask

  task automatic t_busy;
    int n;
    wren; arr_write(0);
    chk("R9", {arr_grant, status[1:0]}, 3'b111);
    cs_n = 0; cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
    chk("R2", status[1], 1);
    cmd_write = 1; @(negedge clk); cmd_write = 0; cs_n = 1;
    chk("R9", arr_deny, 1);
    chk("R10", status[1], 0);
    cs_n = 0; cmd_wren = 1; @(negedge clk); cmd_wren = 0; cs_n = 1;
    chk("R2", status[1], 0);
    wait_busy(n);
    chk("R9", n, W - 3);
    chk("R9", status[1:0], 0);
  endtask

  task automatic t_busy_len;
    int n;
    wren; arr_write(0);
    wait_busy(n);
    chk("R9", n, W);
    chk("R9", status[1:0], 2'b00);
  endtask

  task automatic t_blocks;
    logic [AW-1:0] addrs [3] = '{13'h0FFF, 13'h1000, 13'h1800};
    for (int b = 1; b <= 3; b++) begin
      wren; sr_write({4'h0, 2'(b), 2'b00}, 1, "R4");
      chk("R4", status[3:2], b);
      for (int i = 0; i < 3; i++) begin
        bit prot = (b == 3) || (b == 2 && i >= 1) || (b == 1 && i == 2);
        int n;
        wren; arr_write(addrs[i]);
        chk("R4", {arr_grant, arr_deny}, prot ? 2'b01 : 2'b10);
        if (prot) begin @(negedge clk); chk("R10", status[1], 0); end
        else wait_busy(n);
      end
    end
    wren; sr_write(8'h00, 1, "R4");
  endtask

  task automatic t_pin_lock;
    wren; sr_write(8'h80, 1, "R5"); chk("R5", status, 8'h80);
    wp_n = 0; @(negedge clk);
    wren; sr_write(8'h0C, 0, "R5");
    chk("R5", status, 8'h80);
    wp_n = 1; @(negedge clk);
    wren; sr_write(8'h8C, 1, "R5");
    chk("R5", status, 8'h8C);
  endtask

  task automatic t_cancel;
    wren;
    cs_n = 0; sr_data = 8'h84; cmd_wrsr = 1; @(negedge clk); cmd_wrsr = 0;
    chk("R7", {sr_grant, sr_deny}, 0);
    wp_n = 0; @(negedge clk);
    chk("R7", sr_deny, 1);
    cs_n = 1; @(negedge clk);
    chk("R7", status, 8'h8C);
    chk("R7", sr_grant, 0);
    wp_n = 1; @(negedge clk);
  endtask

  task automatic t_started;
    int n;
    wren;
    cs_n = 0; sr_data = 8'h84; cmd_wrsr = 1; @(negedge clk); cmd_wrsr = 0;
    cs_n = 1; @(negedge clk);
    chk("R8", sr_grant, 1);
    wp_n = 0;
    @(negedge clk);
    wait_busy(n);
    chk("R8", n, W - 1);
    chk("R8", status, 8'h84);
    wp_n = 1; @(negedge clk);
    wren; sr_write(8'h00, 1, "R8");
  endtask

  task automatic t_pin_ignored;
    wp_n = 0; @(negedge clk);
    wren; sr_write(8'h08, 1, "R6");
    chk("R6", status, 8'h08);
    wp_n = 1; @(negedge clk);
  endtask

  task automatic t_readonly_bits;
    wren; sr_write(8'h73, 1, "R11");
    chk("R11", status, 8'h00);
    wren; sr_write(8'hFB, 1, "R11");
    chk("R11", status, 8'h88);
    wren; sr_write(8'h00, 1, "R11");
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1; @(negedge clk);
    t_reset;
    t_latch;
    t_no_latch;
    t_busy;
    t_busy_len;
    t_blocks;
    t_pin_ignored;
    t_readonly_bits;
    t_pin_lock;
    t_cancel;
    t_started;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule